// File: doc/BRIEF.md
# Memory-Mapped Interrupt Level Driver

This block is a bus-slave register through which software raises or lowers one of several interrupt lines. Each line is meant to feed the level-sensitive external interrupt input of one processor: line N goes to processor N. A single 16-bit store carries two fields. The low byte names the target line. The high byte gives the level to place on that line.

The chosen line takes the new level one clock after the store. It then holds that level until a later store names the same line again, so the line is a held level and not a pulse. Stores that name a line which does not exist, or that miss the register, change nothing. Reading the register always returns zero.

Top module: `irq_level_drv`

## Requirements
- R1: While reset is high, and on the first cycle after it, every interrupt line is low.
- R2: A write to byte offset 8 of the 6-bit window with both byte enables set updates the line named by `bus_wdata[7:0]` from the next clock edge. That line goes high if `bus_wdata[15:8]` is nonzero and low if it is zero.
- R3: A line keeps its level until a later accepted write names it. Idle cycles do not change it, and neither do writes to other lines.
- R4: A write with `bus_be` = 2'b01 (only the index byte enabled) treats the level as zero and drives the named line low.
- R5: A write whose index is NPORTS or larger changes no line.
- R6: A write to any offset other than 8 changes no line.
- R7: A write with `bus_be[0]` = 0 carries no index and changes no line.
- R8: `bus_rdata` reads as zero at all times.
- R9: With `bus_we` low, no line changes, whatever the other bus inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | WIN_AW (6) | Byte offset within the window |
| bus_we | input | 1 | Write strobe, one cycle per store |
| bus_be | input | 2 | Byte enables: bit 0 for the index byte, bit 1 for the level byte |
| bus_wdata | input | 16 | Bits 7:0 hold the line index; bits 15:8 hold the level |
| bus_rdata | output | 16 | Read data, always zero |
| irq_o | output | NPORTS (8) | Held interrupt levels, one per processor |

## Verification
The properties assume that each write strobe describes one complete store, and that the address, byte enables and data are steady on the edge where `bus_we` is high. They also assume the bus inputs are never unknown once reset has been released. The stimulus changes inputs only on the falling edge and drives every bus input to a defined value at every step. Random writes pick indexes a little past NPORTS, offsets that both hit and miss the register, and all four byte-enable patterns. Directed stores cover the last line and index 255.

// File: rtl/irq_drv_pkg.sv
package irq_drv_pkg;

    localparam int unsigned IDX_W = 8;
    localparam int unsigned LVL_W = 8;
    localparam int unsigned BUS_DW = IDX_W + LVL_W;

    // One decoded store, handed from the decoder to every line
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic             level;
    } wr_req_t;

    // A missing level byte reads as zero; any nonzero level means asserted
    function automatic logic level_from(input logic en, input logic [LVL_W-1:0] b);
        return en && (b != '0);
    endfunction

endpackage

// File: rtl/irq_drv_decode.sv
module irq_drv_decode
    import irq_drv_pkg::*;
#(
    parameter int unsigned NPORTS  = 8,
    parameter int unsigned WIN_AW  = 6,
    parameter int unsigned REG_OFS = 8
) (
    input  logic              bus_we,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [BUS_DW-1:0] bus_wdata,
    output wr_req_t           req
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NPORTS);

    logic             hit;
    logic             in_range;
    logic [IDX_W-1:0] idx_b;
    logic [LVL_W-1:0] lvl_b;

    always_comb begin
        idx_b    = bus_wdata[IDX_W-1:0];
        lvl_b    = bus_wdata[BUS_DW-1:IDX_W];
        hit      = bus_we && bus_be[0] && (bus_addr == WIN_AW'(REG_OFS));
        in_range = {1'b0, idx_b} < LIMIT;
        req.valid = hit && in_range;
        req.idx   = idx_b;
        req.level = level_from(bus_be[1], lvl_b);
    end
endmodule

// File: rtl/irq_drv_line.sv
module irq_drv_line
    import irq_drv_pkg::*;
#(
    parameter int unsigned LINE_ID = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output logic    level_q
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(LINE_ID);

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else if (req.valid && (req.idx == MY_IDX))
            level_q <= req.level;
    end
endmodule

// File: rtl/irq_level_drv.sv
module irq_level_drv
    import irq_drv_pkg::*;
#(
    parameter int unsigned NPORTS  = 8,
    parameter int unsigned WIN_AW  = 6,
    parameter int unsigned REG_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NPORTS-1:0] irq_o
);
    wr_req_t req;

    irq_drv_decode #(
        .NPORTS (NPORTS),
        .WIN_AW (WIN_AW),
        .REG_OFS(REG_OFS)
    ) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .req      (req)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_line
        irq_drv_line #(.LINE_ID(g)) u_line (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .level_q(irq_o[g])
        );
    end

    // The register is write-only in effect
    assign bus_rdata = '0;
endmodule

// File: rtl/irq_level_drv_chk.sv
module irq_level_drv_chk #(
    parameter int unsigned NPORTS  = 8,
    parameter int unsigned WIN_AW  = 6,
    parameter int unsigned REG_OFS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [WIN_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [1:0]        bus_be,
    input logic [15:0]       bus_wdata,
    input logic [NPORTS-1:0] irq_o
);
    logic rst_seen;
    logic take;

    assign take = bus_we && bus_be[0] && (bus_addr == WIN_AW'(REG_OFS))
                  && ({1'b0, bus_wdata[7:0]} < 9'(NPORTS));

    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            reset_low_chk: assert (irq_o == '0);
        end
    end

    // R2
    target_level_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> irq_o[$past(bus_wdata[7:0])] ==
                 ($past(bus_be[1]) && ($past(bus_wdata[15:8]) != 8'h00)));

    // R3
    others_hold_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ((irq_o ^ $past(irq_o)) &
                  ~(NPORTS'(1) << $past(bus_wdata[7:0]))) == '0);

    // R5
    no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(irq_o));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(irq_o));
endmodule

bind irq_level_drv irq_level_drv_chk #(
    .NPORTS (NPORTS),
    .WIN_AW (WIN_AW),
    .REG_OFS(REG_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_be   (bus_be),
    .bus_wdata(bus_wdata),
    .irq_o    (irq_o)
);

// File: tb/sim_irq_level_drv.sv
`timescale 1ns/1ps
module sim_irq_level_drv;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_be = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [NP-1:0] irq_o;
    logic [NP-1:0] exp_v = '0;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    irq_level_drv #(.NPORTS(NP)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    function automatic logic [NP-1:0] model(input logic [NP-1:0] cur,
        input logic [5:0] a, input logic we, input logic [1:0] be,
        input logic [15:0] d);
        logic [NP-1:0] n = cur;
        if (we && be[0] && a == 6'd8 && int'(d[7:0]) < NP)
            n[d[7:0]] = be[1] && (d[15:8] != 8'h00);
        return n;
    endfunction

    function automatic string tag_of(input logic [5:0] a, input logic we,
        input logic [1:0] be, input logic [15:0] d);
        if (!we) return "R9";
        if (a != 6'd8) return "R6";
        if (!be[0]) return "R7";
        if (int'(d[7:0]) >= NP) return "R5";
        if (!be[1]) return "R4";
        return "R2/R3";
    endfunction

    task automatic check_vec(input string tag, input logic [NP-1:0] exp);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, exp);
        end
    endtask

    task automatic check_rd();
        checks++;
        if (bus_rdata !== 16'h0000) begin
            errors++;
            $display("FAIL R8 bus_rdata actual=%h expected=0000", bus_rdata);
        end
    endtask

    task automatic store(input logic [5:0] a, input logic we,
        input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_be = be; bus_wdata = d;
        exp_v = model(exp_v, a, we, be, d);
        @(negedge clk);
        bus_we = 1'b0;
        check_vec(tag_of(a, we, be, d), exp_v);
    endtask

    initial begin : watchdog
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd4321);
        repeat (3) @(negedge clk);
        check_vec("R1", '0);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R1", '0);
        check_rd();

        store(6'd8, 1, 2'b11, 16'h0102);   // R2 line 2 high
        store(6'd8, 1, 2'b11, 16'h8000);   // R2 line 0 high
        store(6'd8, 1, 2'b11, 16'h0107);   // R2 last line
        repeat (5) @(negedge clk);
        check_vec("R3 hold over idle", exp_v);
        store(6'd8, 1, 2'b11, 16'hFF08);   // R5 index == NPORTS
        store(6'd8, 1, 2'b11, 16'h01FF);   // R5 index 255
        store(6'd9, 1, 2'b11, 16'h0103);   // R6 wrong offset
        store(6'd0, 1, 2'b11, 16'h0104);   // R6 offset 0
        store(6'd8, 1, 2'b10, 16'h0105);   // R7 no index byte
        store(6'd8, 0, 2'b11, 16'h0106);   // R9 no strobe
        store(6'd8, 1, 2'b01, 16'hFF02);   // R4 level byte missing
        store(6'd8, 1, 2'b11, 16'h0007);   // R2 zero level clears
        check_rd();

        for (int i = 0; i < 400; i++) begin
            logic [5:0] a;
            logic [15:0] d;
            a = ($urandom % 3 != 0) ? 6'd8 : 6'($urandom);
            d[7:0]  = 8'($urandom % (NP + 3));
            d[15:8] = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
            store(a, ($urandom % 8) != 0, 2'($urandom), d);
            if (i % 50 == 0) check_rd();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule